// File: doc/BRIEF.md
# Addressed SPI Front End for a Banked Wiper Register File

This block is the serial control front end of a single-channel digital potentiometer. A host talks to it over a four-wire SPI link in mode 0: data is captured on rising serial clock edges, the slave changes its output on falling edges, and every byte is sent most significant bit first. Each transaction is framed by an active-low chip select. The first byte after chip select falls carries a fixed device type code and a two-bit slave address. The block executes a command only if that address matches its two strap inputs, so up to four of these parts can share one bus.

The second byte is an instruction. It selects an operation, a register within a bank and one of four banks. The block holds sixteen 8-bit data registers in four banks of four, plus one 8-bit wiper counter register that drives the tap code output directly. Read and write commands take a third byte, which carries the data. Transfers between the wiper and a data register take two bytes and are allowed only for bank 0.

The serial clock, chip select and data input are expected to be synchronous to the block clock, which must run at least four times faster than the serial clock. Edges are detected by comparing each input with its value in the previous block cycle.

Top module: `pot_spi_if`

## Requirements
- R1: A frame starts when chip select falls. The first 8 bits received after that form the identification byte, and each new chip select low period restarts the byte count from zero.
- R2: The identification byte is accepted only if bits 7:4 equal 4'b0101 and bits 3:2 equal 2'b00. Otherwise the rest of the frame is ignored: no register changes and the data output enable stays low.
- R3: Bits 1:0 of the identification byte must equal the strap input addr_strap_i[1:0]. On a mismatch the rest of the frame is ignored in the same way.
- R4: In the instruction byte, bits 7:4 are the opcode, bits 3:2 are the register number and bits 1:0 are the bank number. The opcodes are: 4'h9 read wiper, 4'hA write wiper, 4'hB read data register, 4'hC write data register, 4'hD data register to wiper, 4'hE wiper to data register, and 4'h0 no-op.
- R5: Data register writes (third byte) and reads work on all sixteen registers in every bank. The register selected is bank*4 + register number.
- R6: A write wiper command loads the third byte into the wiper counter at the end of that byte. tap_o always equals the wiper counter, and a read wiper command returns it.
- R7: Data register to wiper and wiper to data register act at the end of the instruction byte, but only when the bank number is 0. With banks 1 to 3 they change nothing.
- R8: miso_oe_o is high only during the third byte of a read command in a frame whose identification byte was accepted. The read value appears on miso_o MSB first: bit 7 is valid before the 17th rising clock edge, and the output advances on each falling edge after that.
- R9: If chip select rises before a command's final byte is complete, the command is dropped and no register changes.
- R10: After reset, all sixteen data registers and the wiper counter are zero, and miso_oe_o is low.
- R11: Opcodes not listed in R4 do nothing. Bits clocked in after the 24th rising edge of a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select (frames a transaction) |
| sclk_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from the host |
| addr_strap_i | input | 2 | Board-strapped slave address |
| miso_o | output | 1 | Serial read data |
| miso_oe_o | output | 1 | Drive enable for miso_o (low means high impedance) |
| tap_o | output | 8 | Wiper tap code |

## Verification
A corrupted wiper counter shows up on tap_o in the block cycle right after the serial edge that caused it, so every vector compares tap_o after its frame. A wrong data register value cannot be seen until it is read back, so writes to each bank are followed by reads that return the value through miso_o one frame later. A wrong match flag or opcode latch shows up as miso_oe_o rising in a frame that should stay silent, or as a change to tap_o in an ignored or aborted frame. The bench samples the enable on every data bit to catch this.

// File: rtl/pot_spi_pkg.sv
package pot_spi_pkg;
    localparam int DW     = 8;
    localparam int NREG   = 16;
    localparam int IDX_W  = $clog2(NREG);
    localparam int CNT_W  = 5;

    typedef enum logic [3:0] {
        OP_NOP           = 4'h0,
        OP_RD_WIPER      = 4'h9,
        OP_WR_WIPER      = 4'hA,
        OP_RD_DATA       = 4'hB,
        OP_WR_DATA       = 4'hC,
        OP_DATA_TO_WIPER = 4'hD,
        OP_WIPER_TO_DATA = 4'hE
    } opcode_e;

    typedef struct packed {
        logic             sclk;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    rx;
    } shift_t;

    typedef struct packed {
        logic             matched;
        logic [3:0]       op;
        logic [IDX_W-1:0] idx;
        logic             talk;
        logic [DW-1:0]    tx;
    } ctl_t;
endpackage

// File: rtl/pot_spi_shift.sv
module pot_spi_shift
    import pot_spi_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    input  logic             mosi_i,
    output logic             fall_o,
    output logic             byte_done_o,
    output logic [1:0]       byte_idx_o,
    output logic [DW-1:0]    byte_o,
    output logic             data_phase_o
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(3 * DW);
    localparam logic [CNT_W-1:0] DATA_LO   = CNT_W'(2 * DW + 1);

    shift_t sh_d, sh_q;
    logic   rise;

    always_comb begin
        sh_d      = sh_q;
        sh_d.sclk = sclk_i;
        rise      = sclk_i & ~sh_q.sclk & ~cs_n_i;
        if (cs_n_i) begin
            sh_d.cnt = '0;
        end else if (rise) begin
            sh_d.rx = {sh_q.rx[DW-2:0], mosi_i};
            if (sh_q.cnt != LAST_BIT) begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign fall_o       = ~sclk_i & sh_q.sclk & ~cs_n_i;
    assign byte_done_o  = rise && (sh_q.cnt[2:0] == 3'd7) && (sh_q.cnt < LAST_BIT);
    assign byte_idx_o   = sh_q.cnt[4:3];
    assign byte_o       = {sh_q.rx[DW-2:0], mosi_i};
    assign data_phase_o = (sh_q.cnt >= DATA_LO) && (sh_q.cnt < LAST_BIT);
endmodule

// File: rtl/pot_spi_regs.sv
module pot_spi_regs
    import pot_spi_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             wip_en_i,
    input  logic [DW-1:0]    wip_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [DW-1:0]    rd_data_o,
    output logic [DW-1:0]    wiper_o
);
    logic [DW-1:0] mem_d [NREG];
    logic [DW-1:0] mem_q [NREG];
    logic [DW-1:0] wiper_d, wiper_q;

    always_comb begin
        wiper_d = wip_en_i ? wip_data_i : wiper_q;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            mem_d[g] = (wr_en_i && (wr_idx_i == IDX_W'(g))) ? wr_data_i : mem_q[g];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wiper_q <= '0;
        end else begin
            wiper_q <= wiper_d;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
    assign wiper_o   = wiper_q;
endmodule

// File: rtl/pot_spi_if.sv
module pot_spi_if
    import pot_spi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cs_n_i,
    input  logic          sclk_i,
    input  logic          mosi_i,
    input  logic [1:0]    addr_strap_i,
    output logic          miso_o,
    output logic          miso_oe_o,
    output logic [DW-1:0] tap_o
);
    ctl_t             ctl_d, ctl_q;
    logic             fall, byte_done, data_phase;
    logic [1:0]       byte_idx;
    logic [DW-1:0]    rx_byte, rd_data, wiper;
    logic             wr_en, wip_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [DW-1:0]    wr_data, wip_data;

    pot_spi_shift u_shift (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cs_n_i       (cs_n_i),
        .sclk_i       (sclk_i),
        .mosi_i       (mosi_i),
        .fall_o       (fall),
        .byte_done_o  (byte_done),
        .byte_idx_o   (byte_idx),
        .byte_o       (rx_byte),
        .data_phase_o (data_phase)
    );

    pot_spi_regs u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .wip_en_i   (wip_en),
        .wip_data_i (wip_data),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (rd_data),
        .wiper_o    (wiper)
    );

    // register index is bank in the upper two bits, register number below
    assign rd_idx = {rx_byte[1:0], rx_byte[3:2]};

    always_comb begin
        ctl_d    = ctl_q;
        wr_en    = 1'b0;
        wr_idx   = ctl_q.idx;
        wr_data  = rx_byte;
        wip_en   = 1'b0;
        wip_data = rx_byte;
        if (cs_n_i) begin
            ctl_d = '0;
        end else begin
            if (fall && ctl_q.talk && data_phase) begin
                ctl_d.tx = {ctl_q.tx[DW-2:0], 1'b0};
            end
            if (byte_done) begin
                unique case (byte_idx)
                    2'd0: begin
                        ctl_d.matched = (rx_byte[7:4] == DEV_TYPE) &&
                                        (rx_byte[3:2] == 2'b00) &&
                                        (rx_byte[1:0] == addr_strap_i);
                    end
                    2'd1: begin
                        if (ctl_q.matched) begin
                            ctl_d.op  = rx_byte[7:4];
                            ctl_d.idx = rd_idx;
                            case (rx_byte[7:4])
                                OP_RD_WIPER: begin
                                    ctl_d.talk = 1'b1;
                                    ctl_d.tx   = wiper;
                                end
                                OP_RD_DATA: begin
                                    ctl_d.talk = 1'b1;
                                    ctl_d.tx   = rd_data;
                                end
                                OP_DATA_TO_WIPER: begin
                                    wip_en   = (rx_byte[1:0] == 2'b00);
                                    wip_data = rd_data;
                                end
                                OP_WIPER_TO_DATA: begin
                                    wr_en   = (rx_byte[1:0] == 2'b00);
                                    wr_idx  = rd_idx;
                                    wr_data = wiper;
                                end
                                default: ;
                            endcase
                        end
                    end
                    2'd2: begin
                        ctl_d.talk = 1'b0;
                        if (ctl_q.matched) begin
                            wip_en = (ctl_q.op == OP_WR_WIPER);
                            wr_en  = (ctl_q.op == OP_WR_DATA);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign miso_oe_o = ctl_q.talk;
    assign miso_o    = ctl_q.talk & ctl_q.tx[DW-1];
    assign tap_o     = wiper;
endmodule

// File: rtl/pot_spi_if_chk.sv
module pot_spi_if_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cs_n_i,
    input logic       sclk_i,
    input logic       miso_oe_o,
    input logic [7:0] tap_o
);
    // R8
    oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_n_i && $past(cs_n_i)) |-> !miso_oe_o);

    // R8
    oe_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miso_oe_o |-> !$past(cs_n_i));

    // R9
    tap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_n_i && $past(cs_n_i)) |-> $stable(tap_o));

    // R6
    tap_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tap_o) |-> ($past(sclk_i) && !$past(cs_n_i)));
endmodule

bind pot_spi_if pot_spi_if_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (cs_n_i),
    .sclk_i    (sclk_i),
    .miso_oe_o (miso_oe_o),
    .tap_o     (tap_o)
);

// File: tb/pot_spi_if_tb_top.sv
module pot_spi_if_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       miso, miso_oe;
    logic [7:0] tap;

    int total = 0;
    int bad   = 0;
    logic [7:0] rd_byte;
    logic       oe_seen;
    logic       oe_all;

    always #2 clk = ~clk;

    pot_spi_if dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cs_n_i       (cs_n),
        .sclk_i       (sclk),
        .mosi_i       (mosi),
        .addr_strap_i (strap),
        .miso_o       (miso),
        .miso_oe_o    (miso_oe),
        .tap_o        (tap)
    );

    typedef struct packed {
        logic [7:0] id;
        logic [7:0] ins;
        logic [7:0] dat;
        logic [5:0] nb;
        logic       rd;
        logic [7:0] exp_rd;
        logic [7:0] exp_tap;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam logic [50:0] VECS [NV] = '{
        {8'h52, 8'hA0, 8'h3C, 6'd24, 1'b0, 8'h00, 8'h3C, 4'd6},  // R6 write wiper
        {8'h52, 8'h90, 8'h00, 6'd24, 1'b1, 8'h3C, 8'h3C, 4'd6},  // R6 read wiper
        {8'h52, 8'hC4, 8'h5A, 6'd24, 1'b0, 8'h00, 8'h3C, 4'd5},  // R5 bank0 reg1
        {8'h52, 8'hCE, 8'h77, 6'd24, 1'b0, 8'h00, 8'h3C, 4'd5},  // R5 bank2 reg3
        {8'h52, 8'hBE, 8'h00, 6'd24, 1'b1, 8'h77, 8'h3C, 4'd5},  // R5 read bank2 reg3
        {8'h52, 8'hB4, 8'h00, 6'd24, 1'b1, 8'h5A, 8'h3C, 4'd8},  // R8 read bank0 reg1
        {8'h52, 8'hD4, 8'h00, 6'd16, 1'b0, 8'h00, 8'h5A, 4'd7},  // R7 data to wiper bank0
        {8'h52, 8'hDE, 8'h00, 6'd16, 1'b0, 8'h00, 8'h5A, 4'd7},  // R7 bank2 ignored
        {8'h52, 8'hA0, 8'h11, 6'd24, 1'b0, 8'h00, 8'h11, 4'd6},  // R6
        {8'h52, 8'hEE, 8'h00, 6'd16, 1'b0, 8'h00, 8'h11, 4'd7},  // R7 wiper to bank2 ignored
        {8'h52, 8'hBE, 8'h00, 6'd24, 1'b1, 8'h77, 8'h11, 4'd7},  // R7 bank2 unchanged
        {8'h52, 8'hE8, 8'h00, 6'd16, 1'b0, 8'h00, 8'h11, 4'd7},  // R7 wiper to bank0 reg2
        {8'h52, 8'hB8, 8'h00, 6'd24, 1'b1, 8'h11, 8'h11, 4'd7},  // R7 read back
        {8'h62, 8'hA0, 8'hFF, 6'd24, 1'b0, 8'h00, 8'h11, 4'd2},  // R2 bad type
        {8'h56, 8'hA0, 8'hFF, 6'd24, 1'b0, 8'h00, 8'h11, 4'd2},  // R2 bits 3:2 set
        {8'h51, 8'hA0, 8'hFF, 6'd24, 1'b0, 8'h00, 8'h11, 4'd3},  // R3 wrong address
        {8'h53, 8'h90, 8'h00, 6'd24, 1'b0, 8'h00, 8'h11, 4'd3},  // R3 read, wrong address
        {8'h52, 8'hA0, 8'h99, 6'd20, 1'b0, 8'h00, 8'h11, 4'd9},  // R9 abort write wiper
        {8'h52, 8'hC1, 8'hAB, 6'd12, 1'b0, 8'h00, 8'h11, 4'd9},  // R9 abort write bank1
        {8'h52, 8'hB1, 8'h00, 6'd24, 1'b1, 8'h00, 8'h11, 4'd9},  // R9 R10 bank1 reg0 still 0
        {8'h52, 8'h30, 8'hFF, 6'd24, 1'b0, 8'h00, 8'h11, 4'd11}  // R11 unknown opcode
    };

    task automatic check(input bit ok, input int req, input logic [7:0] act,
                         input logic [7:0] exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic frame(input logic [31:0] bits, input int nb);
        rd_byte = '0;
        oe_seen = 1'b0;
        oe_all  = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        for (int k = 0; k < nb; k++) begin
            mosi = bits[31-k];
            repeat (4) @(negedge clk);
            if (k >= 16 && k < 24) begin
                rd_byte = {rd_byte[6:0], miso};
                oe_seen = oe_seen | miso_oe;
                oe_all  = oe_all & miso_oe;
            end
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, 0, 8'h00, 8'h00, "watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(tap == 8'h00, 10, tap, 8'h00, "tap after reset");
        check(miso_oe == 1'b0, 10, {7'd0, miso_oe}, 8'h00, "oe after reset");

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            frame({v.id, v.ins, v.dat, v.dat}, int'(v.nb));
            check(tap == v.exp_tap, int'(v.req), tap, v.exp_tap, $sformatf("tap vec %0d", i));
            if (v.rd) begin
                check(oe_all && rd_byte == v.exp_rd, int'(v.req), rd_byte, v.exp_rd,
                      $sformatf("read vec %0d", i));
            end else begin
                check(!oe_seen, 8, {7'd0, oe_seen}, 8'h00, $sformatf("oe quiet vec %0d", i));
            end
        end

        // R11 bits beyond 24 ignored: trailing byte 33 must not reach the wiper
        frame({8'h52, 8'hA0, 8'h22, 8'h33}, 32);
        check(tap == 8'h22, 11, tap, 8'h22, "extra bits after write");

        // R1 first byte after chip select fall is the ID: an aborted 5-bit
        // prefix must not shift the following frame
        frame({8'hFF, 24'h0}, 5);
        frame({8'h52, 8'hA0, 8'h44, 8'h00}, 24);
        check(tap == 8'h44, 1, tap, 8'h44, "frame restart after short frame");

        // R3 strap change: new address selects the block
        strap = 2'b01;
        frame({8'h52, 8'hA0, 8'h55, 8'h00}, 24);
        check(tap == 8'h44, 3, tap, 8'h44, "old address after strap change");
        frame({8'h51, 8'hA0, 8'h55, 8'h00}, 24);
        check(tap == 8'h55, 3, tap, 8'h55, "new address after strap change");

        // R4 no-op opcode leaves wiper alone, R8 MSB-first on alternating pattern
        frame({8'h51, 8'h00, 8'hFF, 8'h00}, 24);
        check(tap == 8'h55, 4, tap, 8'h55, "no-op opcode");
        frame({8'h51, 8'h90, 8'h00, 8'h00}, 24);
        check(oe_all && rd_byte == 8'h55, 8, rd_byte, 8'h55, "read wiper msb first");

        // R10 reset clears registers
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tap == 8'h00, 10, tap, 8'h00, "tap after second reset");
        frame({8'h51, 8'hBE, 8'h00, 8'h00}, 24);
        check(oe_all && rd_byte == 8'h00, 10, rd_byte, 8'h00, "bank2 reg3 cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule